// File: doc/BRIEF.md
# I2C Register Target with Clear-on-Read Flags

This block is a serial-bus target for a small set of control registers. A fast system clock oversamples the SCL and SDA lines and detects start, stop and data edges. The block answers only to one fixed 7-bit target address. It accepts register writes made of an address byte, a pointer byte and a data byte. It serves reads made of a pointer write followed by a repeated start with the read bit set. SDA is driven only low, through an open-drain enable output.

The register contents are presented in parallel to the surrounding logic. A separate flags register collects event pulses from the fault logic. A bus read of that register returns the collected flags, clears them, and sends a one-cycle release pulse back to the fault logic so that its lockouts can be lifted. The fault logic can also clear the two mode bits of the control register. Reset is asserted asynchronously and is released in step with `clk` by the surrounding reset tree.

Top module: `i2c_regbank`

## Requirements
- R1: After reset the register outputs are control 0x00, flags 0x00, feature 0x52, current 0x0F, monitor 0x80 and ramp 0x00, `sda_oe` is low and `fault_release` is low.
- R2: The target acknowledges by pulling SDA low (asserting `sda_oe`) for the 9th SCL pulse after each byte it receives, but only once the address byte carried 7-bit address 0x63 (binary 1100011). For any other address it acknowledges nothing and ignores the rest of the transfer. `sda_oe` only changes while SCL is low.
- R3: A write transfer is address byte 0xC6 (address 0x63, direction bit 0), then a pointer byte, then a data byte. The data byte lands in the register that the pointer names: 0x01 monitor, 0x06 ramp, 0x08 feature, 0x09 current, 0x0A control.
- R4: A read transfer is a pointer write, a repeated start and address byte 0xC7 (direction bit 1). The target then sends the pointed register MSB first, and it leaves SDA released during the master's acknowledge slot that follows.
- R5: Pointers other than the five writable ones and the flags pointer read as 0x00 and ignore writes. This includes the revision pointer 0x00. The flags register at 0x0B ignores bus writes.
- R6: Loading register 0x0B for a read returns the flags held at that moment and clears them. One cycle later `fault_release` pulses high for exactly one cycle.
- R7: Each high bit of `flag_set` sets the matching bit of flags bits [5:0]. The bit stays set until a flags read. A set that arrives in the same cycle as a read clear survives the clear. Flags bits [7:6] read 0.
- R8: `mode_clr` clears control bits [1:0] on the next clock edge. It wins over a bus write to the control register in the same cycle, while the other bits of that write still land.
- R9: A start or repeated start at any point restarts address reception, and a stop abandons the transfer without a write. After the master declines a read byte with a high acknowledge, the target releases SDA and waits for a start or a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| flag_set | input | 6 | Per-bit event pulses into the flags register |
| mode_clr | input | 1 | Clears control register bits [1:0] |
| ctl_o | output | 8 | Control register (pointer 0x0A) |
| mon_o | output | 8 | Monitor register (pointer 0x01) |
| ramp_o | output | 8 | Ramp register (pointer 0x06) |
| feat_o | output | 8 | Feature register (pointer 0x08) |
| cur_o | output | 8 | Current register (pointer 0x09) |
| flags_o | output | 8 | Flags register (pointer 0x0B) |
| fault_release | output | 1 | One-cycle pulse after a flags read |

## Verification
Every bus result trails the SCL edge that causes it by three clocks: two synchronizer flops and the sequencer register. An acknowledge or a read bit therefore appears three clocks after an SCL fall. A register write lands three clocks after the fall that ends the data byte, and a read load with its flags clear occurs three clocks after the fall that ends the address acknowledge. The bench drives SCL with eight-clock phases and samples SDA in the middle of each high phase, well clear of those three clocks. It times its one-cycle `mode_clr` and `flag_set` pulses to the exact clock of the write or of the read load. Its behavioural register model is compared with every output on every clock while the bus is quiet, and is updated only once a transfer or pulse has settled.

// File: rtl/i2c_regbank_pkg.sv
package i2c_regbank_pkg;

  localparam int DW     = 8;
  localparam int AW     = 8;
  localparam int FLAG_W = 6;
  localparam int MODE_W = 2;

  localparam logic [DW-2:0] DEV_ADDR = 7'h63;

  localparam logic [AW-1:0] A_CTL = 8'h0A;
  localparam logic [AW-1:0] A_FLG = 8'h0B;

  // plain read/write registers: index 0 monitor, 1 ramp, 2 feature, 3 current
  localparam int N_PLAIN = 4;
  localparam logic [N_PLAIN*AW-1:0] PLAIN_ADDR = {8'h09, 8'h08, 8'h06, 8'h01};
  localparam logic [N_PLAIN*DW-1:0] PLAIN_RST  = {8'h0F, 8'h52, 8'h00, 8'h80};

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK,
    ST_WAIT
  } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_s,
  output logic line_q
);

  // chain[STAGES-1] is the synchronized copy, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
    end else begin
      chain <= {chain[STAGES-1:0], line_i};
    end
  end

  assign line_s = chain[STAGES-1];
  assign line_q = chain[STAGES];

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_regbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          scl_q,
  input  logic          sda_s,
  input  logic          sda_q,
  input  logic [DW-1:0] rd_data,
  output logic          sda_oe,
  output logic          wr_en,
  output logic          rd_en,
  output logic [AW-1:0] ptr,
  output logic [DW-1:0] wr_data
);

  localparam int CNT_W = $clog2(DW + 1);

  tgt_state_e     st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [DW-1:0]  rx_q, rx_n;
  logic [DW-1:0]  tx_q, tx_n;
  logic [AW-1:0]  ptr_q, ptr_n;
  logic           rw_q, rw_n;
  logic           oe_q, oe_n;

  logic scl_rise, scl_fall, start_c, stop_c, byte_full, last_tx;

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_c   = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c    = scl_s & scl_q & ~sda_q & sda_s;
  assign byte_full = (cnt_q == CNT_W'(DW));
  assign last_tx   = (cnt_q == CNT_W'(DW - 1));

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    rx_n  = rx_q;
    tx_n  = tx_q;
    ptr_n = ptr_q;
    rw_n  = rw_q;
    wr_en = 1'b0;
    rd_en = 1'b0;
    if (start_c) begin
      st_n  = ST_ADDR;
      cnt_n = '0;
    end else if (stop_c) begin
      st_n  = ST_IDLE;
      cnt_n = '0;
    end else begin
      case (st_q)
        ST_ADDR, ST_PTR, ST_WDAT: begin
          if (scl_rise && !byte_full) begin
            rx_n  = {rx_q[DW-2:0], sda_s};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && byte_full) begin
            cnt_n = '0;
            if (st_q == ST_ADDR) begin
              if (rx_q[DW-1:1] == DEV_ADDR) begin
                rw_n = rx_q[0];
                st_n = ST_ADDR_ACK;
              end else begin
                st_n = ST_WAIT;
              end
            end else if (st_q == ST_PTR) begin
              ptr_n = rx_q;
              st_n  = ST_PTR_ACK;
            end else begin
              wr_en = 1'b1;
              st_n  = ST_WDAT_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              st_n  = ST_RDAT;
              tx_n  = rd_data;
              rd_en = 1'b1;
            end else begin
              st_n = ST_PTR;
            end
          end
        end
        ST_PTR_ACK, ST_WDAT_ACK: begin
          if (scl_fall) begin
            st_n = ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (last_tx) begin
              st_n  = ST_RACK;
              cnt_n = '0;
            end else begin
              tx_n  = {tx_q[DW-2:0], 1'b0};
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            rx_n[0] = sda_s;
          end else if (scl_fall) begin
            if (!rx_q[0]) begin
              st_n  = ST_RDAT;
              tx_n  = rd_data;
              rd_en = 1'b1;
            end else begin
              st_n = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
    oe_n = (st_n == ST_ADDR_ACK) || (st_n == ST_PTR_ACK) || (st_n == ST_WDAT_ACK) ||
           ((st_n == ST_RDAT) && !tx_n[DW-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
      ptr_q <= '0;
      rw_q  <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      rx_q  <= rx_n;
      tx_q  <= tx_n;
      ptr_q <= ptr_n;
      rw_q  <= rw_n;
      oe_q  <= oe_n;
    end
  end

  assign sda_oe  = oe_q;
  assign ptr     = ptr_q;
  assign wr_data = rx_q;

endmodule

// File: rtl/i2c_reg_file.sv
module i2c_reg_file
  import i2c_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  input  logic [FLAG_W-1:0] flag_set,
  input  logic              mode_clr,
  output logic [DW-1:0]     rd_data,
  output logic [N_PLAIN-1:0][DW-1:0] plain_q,
  output logic [DW-1:0]     ctl_q,
  output logic [DW-1:0]     flags_q,
  output logic              release_q
);

  localparam int RSV_W = DW - FLAG_W;

  genvar g;
  generate
    for (g = 0; g < N_PLAIN; g++) begin : g_plain
      logic          hit;
      logic [DW-1:0] r_q;
      assign hit = wr_en && (wr_addr == PLAIN_ADDR[g*AW +: AW]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          r_q <= PLAIN_RST[g*DW +: DW];
        end else if (hit) begin
          r_q <= wr_data;
        end
      end
      assign plain_q[g] = r_q;
    end
  endgenerate

  // control register with hardware mode clear taking priority
  logic          ctl_hit, ctl_en;
  logic [DW-1:0] ctl_r, ctl_n;

  assign ctl_hit = wr_en && (wr_addr == A_CTL);
  assign ctl_en  = ctl_hit || mode_clr;

  always_comb begin
    ctl_n = ctl_hit ? wr_data : ctl_r;
    if (mode_clr) begin
      ctl_n[MODE_W-1:0] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_r <= '0;
    end else if (ctl_en) begin
      ctl_r <= ctl_n;
    end
  end

  // flags: sticky sets, cleared by a read load, new sets survive the clear
  logic              rd_clr;
  logic [FLAG_W-1:0] flg_r, flg_n;
  logic              rel_r;

  assign rd_clr = rd_en && (rd_addr == A_FLG);
  assign flg_n  = (rd_clr ? '0 : flg_r) | flag_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_r <= '0;
      rel_r <= 1'b0;
    end else begin
      flg_r <= flg_n;
      rel_r <= rd_clr;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_PLAIN; i++) begin
      if (rd_addr == PLAIN_ADDR[i*AW +: AW]) begin
        rd_data = plain_q[i];
      end
    end
    if (rd_addr == A_CTL) begin
      rd_data = ctl_r;
    end
    if (rd_addr == A_FLG) begin
      rd_data = {{RSV_W{1'b0}}, flg_r};
    end
  end

  assign ctl_q     = ctl_r;
  assign flags_q   = {{RSV_W{1'b0}}, flg_r};
  assign release_q = rel_r;

endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank
  import i2c_regbank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [FLAG_W-1:0] flag_set,
  input  logic              mode_clr,
  output logic [DW-1:0]     ctl_o,
  output logic [DW-1:0]     mon_o,
  output logic [DW-1:0]     ramp_o,
  output logic [DW-1:0]     feat_o,
  output logic [DW-1:0]     cur_o,
  output logic [DW-1:0]     flags_o,
  output logic              fault_release
);

  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_l, sync_l, prev_l;
  assign raw_l = {sda_i, scl_i};

  genvar g;
  generate
    for (g = 0; g < N_LINES; g++) begin : g_sync
      i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (raw_l[g]),
        .line_s (sync_l[g]),
        .line_q (prev_l[g])
      );
    end
  endgenerate

  logic          wr_en, rd_en;
  logic [AW-1:0] ptr;
  logic [DW-1:0] wr_data, rd_data;
  logic [N_PLAIN-1:0][DW-1:0] plain_q;

  i2c_target_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_s   (sync_l[0]),
    .scl_q   (prev_l[0]),
    .sda_s   (sync_l[1]),
    .sda_q   (prev_l[1]),
    .rd_data (rd_data),
    .sda_oe  (sda_oe),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .ptr     (ptr),
    .wr_data (wr_data)
  );

  i2c_reg_file u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (ptr),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_addr   (ptr),
    .flag_set  (flag_set),
    .mode_clr  (mode_clr),
    .rd_data   (rd_data),
    .plain_q   (plain_q),
    .ctl_q     (ctl_o),
    .flags_q   (flags_o),
    .release_q (fault_release)
  );

  assign mon_o  = plain_q[0];
  assign ramp_o = plain_q[1];
  assign feat_o = plain_q[2];
  assign cur_o  = plain_q[3];

endmodule

// File: rtl/i2c_regbank_chk.sv
module i2c_regbank_chk
  import i2c_regbank_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [FLAG_W-1:0] flag_set,
  input logic              mode_clr,
  input logic [DW-1:0]     ctl_o,
  input logic [DW-1:0]     flags_o,
  input logic              fault_release
);

  localparam int RSV_W = DW - FLAG_W;

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i); // R2

  AST_CLEAR_KEEPS_ONLY_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    fault_release |-> (flags_o == {{RSV_W{1'b0}}, $past(flag_set)})); // R6

  AST_RELEASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_release |=> !fault_release); // R6

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_release |-> ((flags_o & ($past(flags_o) | {{RSV_W{1'b0}}, $past(flag_set)}))
                        == ($past(flags_o) | {{RSV_W{1'b0}}, $past(flag_set)}))); // R7

  AST_MODE_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_clr) |-> (ctl_o[MODE_W-1:0] == '0)); // R8

endmodule

bind i2c_regbank i2c_regbank_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .scl_i         (scl_i),
  .sda_oe        (sda_oe),
  .flag_set      (flag_set),
  .mode_clr      (mode_clr),
  .ctl_o         (ctl_o),
  .flags_o       (flags_o),
  .fault_release (fault_release)
);

// File: tb/i2c_regbank_bench.sv
`timescale 1ns/1ps
module i2c_regbank_bench;

  localparam int H = 8;

  logic       clk, rst_n, scl_m, sda_m, mode_clr, sda_line;
  logic [5:0] flag_set;
  logic       sda_oe, fault_release;
  logic [7:0] ctl_o, mon_o, ramp_o, feat_o, cur_o, flags_o;

  int  n_chk, n_fail, rel_seen, exp_rel, cyc;
  bit  cmp_en, done;
  string tag;
  logic [7:0] e_ctl, e_mon, e_ramp, e_feat, e_cur, e_flg;

  assign sda_line = sda_m & ~sda_oe;

  i2c_regbank u_i2c_regbank (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .flag_set(flag_set), .mode_clr(mode_clr), .ctl_o(ctl_o), .mon_o(mon_o),
    .ramp_o(ramp_o), .feat_o(feat_o), .cur_o(cur_o), .flags_o(flags_o),
    .fault_release(fault_release)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string t, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  always @(posedge clk) if (fault_release === 1'b1) rel_seen++;

  // reference model compared on every clock while the bus is quiet
  always @(negedge clk) begin
    if (cmp_en) begin
      check({ctl_o, mon_o, ramp_o, feat_o, cur_o, flags_o, 6'b0, sda_oe, fault_release} ===
            {e_ctl, e_mon, e_ramp, e_feat, e_cur, e_flg, 8'b0}, tag,
            {ctl_o, mon_o, ramp_o, feat_o, cur_o, flags_o, 6'b0, sda_oe, fault_release},
            {e_ctl, e_mon, e_ramp, e_feat, e_cur, e_flg, 8'b0});
    end
  end

  initial begin
    cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(H); scl_m = 1'b1; w(H); sda_m = 1'b0; w(H); scl_m = 1'b0; w(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(H); scl_m = 1'b1; w(H); sda_m = 1'b1; w(H);
  endtask

  // kind 1: mode_clr on the clock of the write; kind 2: flag_set on the clock of the read load
  task automatic send_byte(input logic [7:0] b, input int kind, input logic [5:0] pb, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(H); scl_m = 1'b1; w(H); scl_m = 1'b0; w(2);
      if (i == 0 && kind == 1) begin mode_clr = 1'b1; w(1); mode_clr = 1'b0; end
    end
    sda_m = 1'b1; w(H); scl_m = 1'b1; w(H/2);
    acked = (sda_line == 1'b0);
    w(H/2); scl_m = 1'b0; w(2);
    if (kind == 2) begin flag_set = pb; w(1); flag_set = '0; end
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit m_ack);
    for (int i = 7; i >= 0; i--) begin
      w(H); scl_m = 1'b1; w(H/2); b[i] = sda_line; w(H/2); scl_m = 1'b0;
    end
    w(2);
    sda_m = m_ack ? 1'b0 : 1'b1; w(H); scl_m = 1'b1; w(H/2);
    if (!m_ack) check(sda_line === 1'b1, "R4 target released during master ack slot", {63'b0, sda_line}, 64'd1);
    w(H/2); scl_m = 1'b0; w(2); sda_m = 1'b1;
  endtask

  task automatic mwrite(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'h01: e_mon = d;
      8'h06: e_ramp = d;
      8'h08: e_feat = d;
      8'h09: e_cur = d;
      8'h0A: e_ctl = d;
      default: ;
    endcase
  endtask

  task automatic mread(input logic [7:0] a, output logic [7:0] v);
    case (a)
      8'h01: v = e_mon;
      8'h06: v = e_ramp;
      8'h08: v = e_feat;
      8'h09: v = e_cur;
      8'h0A: v = e_ctl;
      8'h0B: begin v = e_flg; e_flg = '0; exp_rel++; end
      default: v = 8'h00;
    endcase
  endtask

  task automatic txn_write(input logic [7:0] a, input logic [7:0] d, input int kind, input string t);
    bit ak;
    cmp_en = 1'b0;
    bus_start();
    send_byte(8'hC6, 0, 6'h0, ak); check(ak, "R2 ack of matching address", {63'b0, ak}, 64'd1);
    send_byte(a, 0, 6'h0, ak);     check(ak, "R2 ack of pointer byte", {63'b0, ak}, 64'd1);
    send_byte(d, kind, 6'h0, ak);  check(ak, "R2 ack of data byte", {63'b0, ak}, 64'd1);
    bus_stop(); w(6);
    mwrite(a, d);
    if (kind == 1) e_ctl[1:0] = 2'b00;
    tag = t; cmp_en = 1'b1; w(4);
  endtask

  task automatic txn_read(input logic [7:0] a, input int kind, input logic [5:0] pb,
                          input bit do_stop, input string t);
    bit ak;
    logic [7:0] got, exp;
    cmp_en = 1'b0;
    mread(a, exp);
    bus_start();
    send_byte(8'hC6, 0, 6'h0, ak); check(ak, "R2 ack of address", {63'b0, ak}, 64'd1);
    send_byte(a, 0, 6'h0, ak);     check(ak, "R2 ack of read pointer", {63'b0, ak}, 64'd1);
    bus_start();
    send_byte(8'hC7, kind, pb, ak); check(ak, "R4 ack of read address", {63'b0, ak}, 64'd1);
    recv_byte(got, 1'b0);
    check(got === exp, t, {56'b0, got}, {56'b0, exp});
    e_flg = e_flg | {2'b0, pb};
    if (do_stop) begin
      bus_stop(); w(6);
      check(rel_seen == exp_rel, "R6 release pulse count", rel_seen, exp_rel);
      tag = t; cmp_en = 1'b1; w(4);
    end
  endtask

  initial begin
    bit ak;
    n_chk = 0; n_fail = 0; rel_seen = 0; exp_rel = 0; done = 1'b0; cmp_en = 1'b0;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; mode_clr = 1'b0; flag_set = '0;
    e_ctl = 8'h00; e_mon = 8'h80; e_ramp = 8'h00; e_feat = 8'h52; e_cur = 8'h0F; e_flg = 8'h00;
    tag = "R1 reset values";
    w(5); rst_n = 1'b1; w(4);
    cmp_en = 1'b1; w(8);

    // R3 writes
    txn_write(8'h08, 8'hA5, 0, "R3 feature write");
    txn_write(8'h06, 8'h3C, 0, "R3 ramp write");
    txn_write(8'h01, 8'h07, 0, "R3 monitor write");

    // R2 foreign address: no ack, no effect
    cmp_en = 1'b0;
    bus_start();
    send_byte(8'h44, 0, 6'h0, ak); check(!ak, "R2 no ack for foreign address", {63'b0, ak}, 64'd0);
    send_byte(8'h09, 0, 6'h0, ak); check(!ak, "R2 no ack after foreign address", {63'b0, ak}, 64'd0);
    send_byte(8'h55, 0, 6'h0, ak); check(!ak, "R2 no ack for foreign data", {63'b0, ak}, 64'd0);
    bus_stop(); w(6); tag = "R2 foreign transfer ignored"; cmp_en = 1'b1; w(4);

    // R4 reads
    txn_read(8'h08, 0, 6'h0, 1'b1, "R4 read feature");
    txn_read(8'h01, 0, 6'h0, 1'b1, "R4 read monitor");
    txn_read(8'h09, 0, 6'h0, 1'b1, "R1 R4 read current reset value");

    // R5 unmapped, revision, flags not bus-writable
    txn_write(8'h05, 8'hFF, 0, "R5 unmapped write ignored");
    txn_write(8'h00, 8'h12, 0, "R5 revision write ignored");
    txn_write(8'h0B, 8'h3F, 0, "R5 flags bus write ignored");
    txn_read(8'h05, 0, 6'h0, 1'b1, "R5 unmapped reads zero");
    txn_read(8'h00, 0, 6'h0, 1'b1, "R5 revision reads zero");
    txn_read(8'h0B, 0, 6'h0, 1'b1, "R5 R6 flags still zero");

    // R7 flag sets accumulate, R6 read returns and clears
    cmp_en = 1'b0; flag_set = 6'h15; w(1); flag_set = '0; w(2);
    e_flg = 8'h15; tag = "R7 flag set"; cmp_en = 1'b1; w(4);
    cmp_en = 1'b0; flag_set = 6'h02; w(1); flag_set = '0; w(2);
    e_flg = 8'h17; tag = "R7 flag accumulate"; cmp_en = 1'b1; w(4);
    txn_read(8'h0B, 0, 6'h0, 1'b1, "R6 flags read then cleared");

    // R7 set in the clear cycle survives
    cmp_en = 1'b0; flag_set = 6'h01; w(1); flag_set = '0; w(2);
    e_flg = 8'h01; tag = "R7 flag set"; cmp_en = 1'b1; w(4);
    txn_read(8'h0B, 2, 6'h08, 1'b1, "R7 set during clear survives");
    txn_read(8'h0B, 0, 6'h0, 1'b1, "R6 R7 surviving flag read");

    // R8 mode clear
    txn_write(8'h0A, 8'h23, 0, "R3 control write");
    cmp_en = 1'b0; mode_clr = 1'b1; w(1); mode_clr = 1'b0; w(2);
    e_ctl[1:0] = 2'b00; tag = "R8 mode clear"; cmp_en = 1'b1; w(4);
    txn_write(8'h0A, 8'hF3, 1, "R8 mode clear beats same-cycle write");

    // R9 stop before data, repeated start mid-write, restart after NACK
    cmp_en = 1'b0;
    bus_start();
    send_byte(8'hC6, 0, 6'h0, ak); send_byte(8'h06, 0, 6'h0, ak);
    bus_stop(); w(6); tag = "R9 stop abandons write"; cmp_en = 1'b1; w(4);
    cmp_en = 1'b0;
    bus_start();
    send_byte(8'hC6, 0, 6'h0, ak); send_byte(8'h06, 0, 6'h0, ak);
    bus_start();
    send_byte(8'hC6, 0, 6'h0, ak); check(ak, "R9 ack after repeated start", {63'b0, ak}, 64'd1);
    send_byte(8'h09, 0, 6'h0, ak); send_byte(8'h07, 0, 6'h0, ak);
    bus_stop(); w(6); e_cur = 8'h07; tag = "R9 repeated start restarts"; cmp_en = 1'b1; w(4);
    txn_read(8'h09, 0, 6'h0, 1'b0, "R9 read before restart");
    bus_start();
    send_byte(8'hC6, 0, 6'h0, ak); check(ak, "R9 ack after NACKed read", {63'b0, ak}, 64'd1);
    send_byte(8'h01, 0, 6'h0, ak); send_byte(8'h55, 0, 6'h0, ak);
    bus_stop(); w(6); e_mon = 8'h55; tag = "R9 write after NACKed read"; cmp_en = 1'b1; w(8);

    cmp_en = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule